// File: doc/BRIEF.md
# Byte-wide SPI port with software-managed slave select

This block moves one byte at a time over a four-wire serial link. The byte goes out most significant bit first while the byte arriving from the far end is shifted in on the same clock. As master, the block makes the serial clock from the system clock and starts a transfer when software writes the data register. As slave, it follows an external serial clock, which it first brings into the system clock domain.

The slave select seen by the logic can come from the select pin or from a level bit in a register. With the software source, the pin is ignored and a single slave can sit on a bus with no select wire. The rule for a legal data write depends on the clock phase. Under phase 0 the select line must be high between bytes. Under phase 1 it may stay low across a burst. A write that breaks the rule is dropped and sets a collision flag. The shift in progress is not touched.

Software reaches four byte-wide registers through a small port. The `reg_sel` address picks one of them:

| `reg_sel` | Register | Access | Contents |
|---|---|---|---|
| 0 | Control | read/write | enable, role, clock idle level, clock phase, rate code |
| 1 | Status | read-only | completion flag, collision flag |
| 2 | Select | read/write | select source, software select level |
| 3 | Data | read/write | write: byte to send; read: last byte received |

Top module: `spi_port`

## Requirements
- R1: The control register at address 0 holds: bit 0 enable, bit 1 master role, bit 2 clock idle level, bit 3 clock phase, bits 6:4 rate code k. As enabled master, `sck_o` idles at the idle level and, during a byte, toggles 16 times with 2^k system clocks between toggles. A transfer begins with the system clock edge that takes the data write.
- R2: Data moves MSB first and full duplex. With phase 0, bit 7 is on the data output from the data write (master) or from the load (slave) onward. Input is sampled on the leading clock edge and the output moves on the trailing edge. With phase 1, the output moves on the leading edge and input is sampled on the trailing edge.
- R3: After the eighth sampled bit, status bit 0 (completion) sets and the received byte is readable at address 3.
- R4: A read of status (address 1) followed by a read or write of address 3 clears status bit 0 and status bit 1. An access to address 3 without that earlier status read leaves both bits set.
- R5: The select register at address 2 holds bit 0 (source select) and bit 1 (software level). When bit 0 is 1, the internal select equals bit 1 and `ss_n_i` has no effect.
- R6: An enabled master starts nothing while the internal select is low. A data write in that state is dropped without a flag, and `sck_o` stays at the idle level.
- R7: A slave with phase 1 keeps shifting across bytes while the internal select stays low. A data write between bytes is accepted and is sent in the next byte.
- R8: A slave with phase 0 takes a data write only while the internal select is high. A data write while it is low sets status bit 1 and is dropped, so the next byte sends the old shift contents.
- R9: A data write while a byte is in progress, in either role, sets status bit 1 and is dropped. The byte in flight completes unchanged.
- R10: `miso_oe` is high only for an enabled slave with the internal select low. `sck_oe` and `mosi_oe` are high only for an enabled master.
- R11: After reset, control, status and data read as 0, the select register reads 2 (pin source, level high), and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out |
| miso_oe | output | 1 | Master-in drive enable (slave, selected) |
| ss_n_i | input | 1 | Slave select pin, active low |

## Verification
A wrong bit count or a wrong half-period counter shows up at once in master mode. The clock toggles fall in the wrong system cycle, or the data line holds the wrong bit within one half period, so the bench compares both lines every cycle. A dropped write that still reaches the shift register cannot be seen until the next byte leaves the slave. The collision cases are therefore each followed by a full byte whose outgoing bits are checked. Flag state that goes wrong shows in the next status read, including the case where the flags stay set after a data access with no status read before it.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int RATE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  localparam int HALF_MAX = 1 << ((1 << RATE_W) - 1);
  localparam int PRE_W = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic              en, master, cpol, cpha;
  logic [RATE_W-1:0] rate;
  logic              soft_en, soft_lvl;
  logic              done, wcol, stat_seen;
  logic [7:0]        sreg, rxbuf;
  logic              out_bit, act, sckn;
  logic [2:0]        cnt;
  logic [3:0]        hcnt;
  logic [PRE_W-1:0]  pre;
  logic [2:0]        sck_s;
  logic [1:0]        mosi_s, ss_s;

  logic [PRE_W:0]    half;
  logic [PRE_W-1:0]  half_m1;
  logic ss_int, wr_data, data_acc, coll, m_block, accept, tick;
  logic nl, pl, s_on, lead, trail, sample, drive, din, last;
  logic [7:0] sh_next;

  assign half     = (PRE_W+1)'(1) << rate;
  assign half_m1  = half[PRE_W-1:0] - PRE_W'(1);
  assign ss_int   = soft_en ? soft_lvl : ss_s[1];
  assign wr_data  = reg_wr && reg_sel == 2'd3;
  assign data_acc = (reg_wr || reg_rd) && reg_sel == 2'd3;
  assign coll     = en && (act || (!master && !cpha && !ss_int));
  assign m_block  = en && master && !ss_int;
  assign accept   = wr_data && !coll && !m_block;
  assign tick     = en && master && act && pre == half_m1;
  assign nl       = sck_s[1] ^ cpol;
  assign pl       = sck_s[2] ^ cpol;
  assign s_on     = en && !master && !ss_int;
  assign lead     = master ? (tick && !sckn) : (s_on && nl && !pl);
  assign trail    = master ? (tick && sckn)  : (s_on && !nl && pl);
  assign sample   = cpha ? trail : lead;
  assign drive    = cpha ? lead : trail;
  assign din      = master ? miso_i : mosi_s[1];
  assign last     = sample && cnt == 3'd7;
  assign sh_next  = {sreg[6:0], din};

  assign sck_o   = cpol ^ sckn;
  assign sck_oe  = en && master;
  assign mosi_o  = out_bit;
  assign mosi_oe = en && master;
  assign miso_o  = out_bit;
  assign miso_oe = en && !master && !ss_int;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 8'({rate, cpha, cpol, master, en});
      2'd1:    reg_rdata = {6'd0, wcol, done};
      2'd2:    reg_rdata = {6'd0, soft_lvl, soft_en};
      default: reg_rdata = rxbuf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, master, cpol, cpha} <= '0;
      rate      <= '0;
      soft_en   <= 1'b0;
      soft_lvl  <= 1'b1;
      done      <= 1'b0;
      wcol      <= 1'b0;
      stat_seen <= 1'b0;
      sreg      <= '0;
      rxbuf     <= '0;
      out_bit   <= 1'b0;
      act       <= 1'b0;
      sckn      <= 1'b0;
      cnt       <= '0;
      hcnt      <= '0;
      pre       <= '0;
      sck_s     <= '0;
      mosi_s    <= '0;
      ss_s      <= 2'b11;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      ss_s   <= {ss_s[0], ss_n_i};

      if (reg_wr && reg_sel == 2'd0) begin
        en     <= reg_wdata[0];
        master <= reg_wdata[1];
        cpol   <= reg_wdata[2];
        cpha   <= reg_wdata[3];
        rate   <= reg_wdata[4 +: RATE_W];
      end
      if (reg_wr && reg_sel == 2'd2) begin
        soft_en  <= reg_wdata[0];
        soft_lvl <= reg_wdata[1];
      end

      if (reg_rd && reg_sel == 2'd1) stat_seen <= 1'b1;
      if (data_acc && stat_seen) begin
        done      <= 1'b0;
        wcol      <= 1'b0;
        stat_seen <= 1'b0;
      end
      if (wr_data && coll) wcol <= 1'b1;

      if (drive) out_bit <= sreg[7];
      if (accept) begin
        sreg    <= reg_wdata;
        out_bit <= reg_wdata[7];
      end
      if (accept && en && master) begin
        act  <= 1'b1;
        sckn <= 1'b0;
        hcnt <= '0;
        cnt  <= '0;
      end

      if (en && master && act) pre <= tick ? '0 : pre + PRE_W'(1);
      if (accept && en && master) pre <= '0;
      if (tick) begin
        sckn <= !sckn;
        hcnt <= hcnt + 4'd1;
        if (hcnt == 4'd15) act <= 1'b0;
      end
      if (!master && lead) act <= 1'b1;

      if (sample) begin
        sreg <= sh_next;
        cnt  <= cnt + 3'd1;
      end
      if (last) begin
        rxbuf <= sh_next;
        done  <= 1'b1;
        if (!master) act <= 1'b0;
      end

      if (en && !master && ss_int) begin
        cnt <= '0;
        act <= 1'b0;
      end
      if (!en) begin
        act  <= 1'b0;
        cnt  <= '0;
        sckn <= 1'b0;
        pre  <= '0;
        hcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       master,
  input logic       cpol,
  input logic       act,
  input logic       ss_int,
  input logic       sck_o,
  input logic       miso_oe,
  input logic       done,
  input logic       wcol,
  input logic [2:0] cnt,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_sel
);
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && !act) |-> sck_o == cpol);

  p_miso_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (en && !master && !ss_int));

  p_wcol_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && reg_wr && reg_sel == 2'd3) |=> wcol);

  p_done_eighth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt) == 3'd7);

  p_clear_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(reg_sel == 2'd3 && (reg_rd || reg_wr)));

  p_master_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && !ss_int && !act) |=> (!act || !master || !en));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
  .act(act), .ss_int(ss_int), .sck_o(sck_o), .miso_oe(miso_oe),
  .done(done), .wcol(wcol), .cnt(cnt), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_sel(reg_sel)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int vec = 0;
  int bad = 0;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic check_after(string tag, logic [7:0] rx, logic [1:0] flags);
    logic [7:0] d;
    rd(2'd3, d); chk({tag, " R3 received byte"}, d, rx);
    rd(2'd1, d); chk({tag, " R4 flags kept without status read"}, d, {6'd0, flags});
    rd(2'd3, d);
    rd(2'd1, d); chk({tag, " R4 flags cleared"}, d, 8'd0);
    rd(2'd3, d);
  endtask

  task automatic master_xfer(logic cpol, logic cpha, logic [2:0] rate,
                             logic [7:0] tx, logic [7:0] rx, logic collide);
    int h;
    h = 1 << rate;
    wr(2'd0, {1'b0, rate, cpha, cpol, 1'b1, 1'b1});
    @(negedge clk);
    chk("R1 idle level", {7'd0, sck_o}, {7'd0, cpol});
    chk("R10 master enables", {6'd0, sck_oe, mosi_oe}, 8'd3);
    miso_i = rx[7];
    reg_sel = 2'd3; reg_wdata = tx; reg_wr = 1'b1;
    for (int s = 0; s < 16 * h + 4; s++) begin
      int n, j;
      @(negedge clk);
      reg_wr = collide && s == 2;
      if (collide && s == 2) reg_wdata = ~tx;
      n = s / h;
      if (n > 16) n = 16;
      j = cpha ? ((n == 0) ? 0 : (n - 1) / 2) : n / 2;
      chk("R1 sck per cycle", {7'd0, sck_o}, {7'd0, cpol ^ n[0]});
      if (n < 16) begin
        chk(collide ? "R9 R2 mosi per cycle" : "R2 mosi per cycle",
            {7'd0, mosi_o}, {7'd0, tx[7-j]});
        miso_i = rx[7-j];
      end
    end
    check_after("master", rx, {collide, 1'b1});
  endtask

  task automatic slave_xfer(logic cpol, logic cpha, logic pin,
                            logic [7:0] m, logic [7:0] tx, logic midwr);
    if (pin) begin
      sck_i = cpol;
      repeat (8) @(negedge clk);
      ss_n_i = 1'b0;
      repeat (8) @(negedge clk);
      chk("R10 miso enable while selected", {7'd0, miso_oe}, 8'd1);
    end
    if (!cpha) mosi_i = m[7];
    for (int j = 0; j < 8; j++) begin
      if (!cpha) begin
        repeat (8) @(negedge clk);
        chk("R2 slave out phase 0", {7'd0, miso_o}, {7'd0, tx[7-j]});
        sck_i = ~cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
        if (j < 7) mosi_i = m[6-j];
      end else begin
        sck_i = ~cpol;
        repeat (4) @(negedge clk);
        mosi_i = m[7-j];
        repeat (4) @(negedge clk);
        chk(midwr ? "R9 slave out kept" : "R2 slave out phase 1",
            {7'd0, miso_o}, {7'd0, tx[7-j]});
        if (midwr && j == 3) begin
          reg_sel = 2'd3; reg_wdata = ~tx; reg_wr = 1'b1;
          @(negedge clk);
          reg_wr = 1'b0;
        end
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    if (pin) begin
      ss_n_i = 1'b1;
      repeat (8) @(negedge clk);
      chk("R10 miso released", {7'd0, miso_oe}, 8'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 enables at reset", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'd0);
    rd(2'd0, d); chk("R11 control", d, 8'd0);
    rd(2'd1, d); chk("R11 status", d, 8'd0);
    rd(2'd2, d); chk("R11 select", d, 8'd2);
    rd(2'd3, d); chk("R11 data", d, 8'd0);

    master_xfer(1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b0, 3'd1, 8'h5E, 8'hC1, 1'b0);
    master_xfer(1'b0, 1'b1, 3'd2, 8'h81, 8'h7E, 1'b1);
    master_xfer(1'b1, 1'b1, 3'd7, 8'hF0, 8'h0F, 1'b0);
    master_xfer(1'b0, 1'b0, 3'd3, 8'h69, 8'hD2, 1'b1);

    // R6: master with software select low
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h42);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk("R6 clock idle while deselected", {7'd0, sck_o}, 8'd1);
    end
    rd(2'd1, d); chk("R6 no flags", d, 8'd0);
    rd(2'd3, d);
    wr(2'd2, 8'h00);

    // R8/R2: slave phase 0, pin select
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk("R10 slave enables", {6'd0, sck_oe, mosi_oe}, 8'd0);
    wr(2'd3, 8'hA5);
    slave_xfer(1'b0, 1'b0, 1'b1, 8'h3C, 8'hA5, 1'b0);
    check_after("slave0", 8'h3C, 2'b01);

    wr(2'd0, 8'h05);
    wr(2'd3, 8'h96);
    slave_xfer(1'b1, 1'b0, 1'b1, 8'h6B, 8'h96, 1'b0);
    check_after("slave0 idle high", 8'h6B, 2'b01);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    wr(2'd3, 8'h11);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R8 collision while selected", d, 8'h02);
    rd(2'd3, d);
    rd(2'd1, d); chk("R4 collision cleared", d, 8'd0);
    rd(2'd3, d);
    slave_xfer(1'b1, 1'b0, 1'b1, 8'h24, 8'h6B, 1'b0);
    check_after("R8 dropped write", 8'h24, 2'b01);

    // R7/R5: slave phase 1, software select, burst
    sck_i = 1'b0;
    repeat (8) @(negedge clk);
    wr(2'd0, 8'h09);
    wr(2'd2, 8'h01);
    repeat (4) @(negedge clk);
    chk("R5 pin ignored, selected", {7'd0, miso_oe}, 8'd1);
    wr(2'd3, 8'hC3);
    slave_xfer(1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b0);
    check_after("R7 byte 1", 8'h5A, 2'b01);
    wr(2'd3, 8'h7E);
    slave_xfer(1'b0, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b1);
    check_after("R7 byte 2", 8'h81, 2'b11);

    ss_n_i = 1'b0;
    wr(2'd2, 8'h03);
    repeat (6) @(negedge clk);
    chk("R5 pin ignored, deselected", {7'd0, miso_oe}, 8'd0);
    ss_n_i = 1'b1;

    summary();
    $finish;
  end
endmodule